// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block gathers interrupt requests from five sources (vertical blank, display status, timer overflow, serial transfer complete and a keypad edge detector) and offers the most urgent one to an 8-bit processor core, together with the fixed address that the core jumps to. Software sees two byte-wide registers on a simple memory-mapped bus. One holds the pending requests and the other holds the per-source enables. Both use the same bit order.

The core supplies a master enable that gates dispatch. When the core takes the interrupt, it pulses an acknowledge, and the controller clears the flag of the source it was presenting. A separate pending output ignores the master enable, so a halted core can be woken even while dispatch is off. The four keypad lines idle high. A falling edge on any of them raises the keypad request.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the flag and enable registers hold zero. A read of address 0xFF0F returns 0xE0, a read of 0xFFFF returns 0x00, irqPending and irqTake are low, and irqVector is 0x0000.
- R2: Flag bits have fixed meanings: bit 0 vertical blank, bit 1 display status, bit 2 timer overflow, bit 3 serial complete, bit 4 keypad. A high on srcReq[n] (n = 0..3) during a cycle sets flag bit n at the next edge. A read of 0xFF0F returns the flags in bits 4..0 and ones in bits 7..5.
- R3: The enable register lives at 0xFFFF. It stores and reads back all 8 bits written. A 1 in bit n (n = 0..4) enables source n, and a 0 masks it.
- R4: irqPending is high exactly when (flags AND enable[4:0]) is nonzero. This holds whatever the state of masterEn.
- R5: irqTake is high exactly when masterEn is high and irqPending is high.
- R6: While a request is pending, irqVector is 0x0040 + 8 × n, where n is the lowest set bit of (flags AND enable). Bit 0 has the highest priority. When nothing is pending, irqVector is 0x0000.
- R7: An irqAck in a cycle clears, at the next edge, only the flag bit of the source being presented in that cycle. All other flags are kept.
- R8: A request that arrives in the same cycle as an acknowledge is not lost. This applies to a different bit and also to the bit being acknowledged.
- R9: A bus write to 0xFF0F loads bits 4..0 into the flags, so software can both set and clear requests. Requests arriving in the same cycle are ORed into the loaded value.
- R10: When any keyLines bit goes from 1 to 0 between consecutive cycles, flag bit 4 is set. A line held low and a rising edge both leave flag bit 4 unchanged. The previous-line state resets to all ones.
- R11: Writes to any address other than 0xFF0F and 0xFFFF change neither register, and reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Register bus address |
| busWrData | input | 8 | Register bus write data |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| srcReq | input | 4 | One-cycle requests: vertical blank, display status, timer, serial |
| keyLines | input | 4 | Keypad lines, idle high, synchronous to clk |
| masterEn | input | 1 | Master enable from the core |
| irqAck | input | 1 | Core has taken the presented interrupt |
| irqPending | output | 1 | A flagged, enabled source exists (wake indication) |
| irqTake | output | 1 | Dispatch request to the core |
| irqVector | output | 16 | Jump address of the presented source |

## Verification
The bench targets the cycles in which two causes touch the flag register together. These are an acknowledge alongside a new request on the other bit or on the same bit, and a software write alongside a pending state. A design that cleared the whole register, or that let the acknowledge win over a same-bit request, would lose an interrupt. A design that took the wrong end of the priority chain would show the timer vector while vertical blank is pending. The bench checks that the wake output stays high with the master enable low, since a design that gated it would leave a halted core asleep. It also checks keypad lines that stay low or rise, because a level-sensitive detector would keep re-raising the keypad request after software clears it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_COUNT = 5;
  localparam int KEY_BIT   = 4;

  typedef logic [SRC_COUNT-1:0] srcMask_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     flagWr;
    logic     enWr;
    logic     rdFlag;
    logic     rdEn;
    srcMask_t ackMask;
  } irqStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 16'hFF0F,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'hFFFF,
  parameter int VEC_BASE    = 'h40,
  parameter int VEC_STRIDE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  srcMask_t          flags,
  input  srcMask_t          enLow,
  input  logic              masterEn,
  input  logic              irqAck,
  output irqStrobe_t        strobe,
  output logic              irqPending,
  output logic              irqTake,
  output logic [ADDR_W-1:0] irqVector
);
  localparam int LAST_VEC = VEC_BASE + (SRC_COUNT - 1) * VEC_STRIDE;

  srcMask_t live;
  srcMask_t grant;
  logic     hitFlag;
  logic     hitEn;

  assign live    = flags & enLow;
  assign hitFlag = (busAddr == FLAG_ADDR);
  assign hitEn   = (busAddr == ENABLE_ADDR);

  // fixed priority: descending scan, so the lowest set bit is written last
  always_comb begin
    grant     = '0;
    irqVector = '0;
    for (int i = SRC_COUNT - 1; i >= 0; i--) begin
      if (live[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        irqVector = ADDR_W'(VEC_BASE + i * VEC_STRIDE);
      end
    end
  end

  assign irqPending = |live;
  assign irqTake    = masterEn & irqPending;

  always_comb begin
    strobe.flagWr  = busWrEn & hitFlag;
    strobe.enWr    = busWrEn & hitEn;
    strobe.rdFlag  = hitFlag;
    strobe.rdEn    = hitEn;
    strobe.ackMask = irqAck ? grant : '0;
  end

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_grant_is_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~live) == '0);

  assert_vector_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (int'(irqVector) >= VEC_BASE && int'(irqVector) <= LAST_VEC));

  assert_take_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!masterEn) |-> !irqTake);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEY_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqStrobe_t           strobe,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic [SRC_COUNT-2:0] srcReq,
  input  logic [KEY_W-1:0]     keyLines,
  output srcMask_t             flags,
  output srcMask_t             enLow,
  output logic [DATA_W-1:0]    busRdData
);
  localparam int PAD_W = DATA_W - SRC_COUNT;

  logic [DATA_W-1:0] enables;
  logic [KEY_W-1:0]  keyPrev;
  logic              keyFall;
  srcMask_t          newReq;
  srcMask_t          flagBase;
  srcMask_t          flagNext;

  assign keyFall  = |(keyPrev & ~keyLines);
  assign newReq   = {keyFall, srcReq};
  assign flagBase = strobe.flagWr ? busWrData[SRC_COUNT-1:0] : flags;
  // clear acknowledged bit first, then merge fresh requests so none is lost
  assign flagNext = (flagBase & ~strobe.ackMask) | newReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags   <= '0;
      enables <= '0;
      keyPrev <= '1;
    end else begin
      flags   <= flagNext;
      keyPrev <= keyLines;
      if (strobe.enWr) enables <= busWrData;
    end
  end

  assign enLow = enables[SRC_COUNT-1:0];

  always_comb begin
    if (strobe.rdFlag)    busRdData = {{PAD_W{1'b1}}, flags};
    else if (strobe.rdEn) busRdData = enables;
    else                  busRdData = '0;
  end

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|newReq) |=> ((flags & $past(newReq)) == $past(newReq)));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((|strobe.ackMask) && !strobe.flagWr && ((strobe.ackMask & newReq) == '0))
      |=> ((flags & $past(strobe.ackMask)) == '0));

  assert_ack_keeps_others_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((|strobe.ackMask) && !strobe.flagWr)
      |=> ((flags & ~$past(strobe.ackMask)) == ($past(flags) & ~$past(strobe.ackMask))) ||
          (|$past(newReq)));

  assert_key_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(keyPrev & ~keyLines)) |=> flags[KEY_BIT]);

  assert_enable_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enWr |=> $stable(enables));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 16'hFF0F,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'hFFFF,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic                 busWrEn,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [SRC_COUNT-2:0] srcReq,
  input  logic [KEY_W-1:0]     keyLines,
  input  logic                 masterEn,
  input  logic                 irqAck,
  output logic                 irqPending,
  output logic                 irqTake,
  output logic [ADDR_W-1:0]    irqVector
);
  irqStrobe_t strobe;
  srcMask_t   flags;
  srcMask_t   enLow;

  irq_ctrl #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .ENABLE_ADDR(ENABLE_ADDR),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .flags(flags), .enLow(enLow), .masterEn(masterEn), .irqAck(irqAck),
    .strobe(strobe), .irqPending(irqPending), .irqTake(irqTake),
    .irqVector(irqVector)
  );

  irq_datapath #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .srcReq(srcReq), .keyLines(keyLines), .flags(flags), .enLow(enLow),
    .busRdData(busRdData)
  );
endmodule

// File: tb/test_irq_arbiter.sv
`timescale 1ns/100ps
module test_irq_arbiter;
  typedef struct {
    logic        pend;
    logic        take;
    logic [15:0] vec;
    logic [7:0]  rd;
    string       tag;
  } expect_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic [7:0]  busWrData = 8'h00;
  logic        busWrEn = 1'b0;
  logic [7:0]  busRdData;
  logic [3:0]  srcReq = 4'h0;
  logic [3:0]  keyLines = 4'hF;
  logic        masterEn = 1'b0;
  logic        irqAck = 1'b0;
  logic        irqPending;
  logic        irqTake;
  logic [15:0] irqVector;

  expect_t q[$];
  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  // requirement-level model state
  logic [4:0] mFlags = '0;
  logic [7:0] mEn = '0;
  logic [3:0] mKeyPrev = 4'hF;

  always #2.5 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .srcReq(srcReq),
    .keyLines(keyLines), .masterEn(masterEn), .irqAck(irqAck),
    .irqPending(irqPending), .irqTake(irqTake), .irqVector(irqVector)
  );

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic w,
                      input logic [3:0] s, input logic [3:0] k, input logic m,
                      input logic ak, input string tag);
    expect_t e;
    logic [4:0] live, grant, base, fresh;
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = w; srcReq = s;
    keyLines = k; masterEn = m; irqAck = ak;
    #0.5;
    live = mFlags & mEn[4:0];
    grant = live & (~live + 5'd1);
    e.pend = |live;
    e.take = m & e.pend;
    e.vec = 16'h0000;
    for (int i = 0; i < 5; i++)
      if (grant[i]) e.vec = 16'h0040 + 16'(8 * i);
    e.rd = (a == 16'hFF0F) ? {3'b111, mFlags} : (a == 16'hFFFF) ? mEn : 8'h00;
    e.tag = tag;
    q.push_back(e);
    base = (w && a == 16'hFF0F) ? d[4:0] : mFlags;
    fresh = {|(mKeyPrev & ~k), s};
    mFlags = (base & ~(ak ? grant : 5'd0)) | fresh;
    if (w && a == 16'hFFFF) mEn = d;
    mKeyPrev = k;
  endtask

  task automatic idle(input logic [15:0] a, input logic m, input string tag);
    step(a, 8'h00, 1'b0, 4'h0, 4'hF, m, 1'b0, tag);
  endtask

  // monitor: compare outputs against queued expectations
  initial begin
    expect_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        applied++;
        if (irqPending !== e.pend || irqTake !== e.take ||
            irqVector !== e.vec || busRdData !== e.rd) begin
          miscompares++;
          $display("FAIL %s: got pend=%b take=%b vec=%h rd=%h, expected pend=%b take=%b vec=%h rd=%h",
                   e.tag, irqPending, irqTake, irqVector, busRdData,
                   e.pend, e.take, e.vec, e.rd);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    idle(16'hFF0F, 1'b0, "R1 flag read after reset");
    idle(16'hFFFF, 1'b0, "R1 enable read after reset");
    // R2 timer request while masked; R4 no pending
    step(16'hFF0F, 8'h00, 0, 4'b0100, 4'hF, 0, 0, "R2 timer pulse");
    idle(16'hFF0F, 1'b0, "R2 flag shows timer, R4 masked");
    // R3 enable write/readback
    step(16'hFFFF, 8'hFF, 1, 4'h0, 4'hF, 0, 0, "R3 write enables");
    idle(16'hFFFF, 1'b0, "R3 readback, R4 pending with master off");
    idle(16'h0000, 1'b1, "R5 take with master on, R6 timer vector");
    // R6 priority
    step(16'h0000, 8'h00, 0, 4'b0001, 4'hF, 1, 0, "R6 vblank pulse");
    idle(16'hFF0F, 1'b1, "R6 vblank wins");
    // R7 ack clears only dispatched
    step(16'hFF0F, 8'h00, 0, 4'h0, 4'hF, 1, 1, "R7 ack vblank");
    idle(16'hFF0F, 1'b1, "R7 timer remains");
    // R8 ack with new request on other bit
    step(16'hFF0F, 8'h00, 0, 4'b1000, 4'hF, 1, 1, "R8 ack timer with serial");
    idle(16'hFF0F, 1'b1, "R8 serial kept");
    // R8 same-bit re-raise
    step(16'hFF0F, 8'h00, 0, 4'b1000, 4'hF, 1, 1, "R8 ack serial with serial");
    idle(16'hFF0F, 1'b1, "R8 serial survives");
    // R9 software write
    step(16'hFF0F, 8'h12, 1, 4'h0, 4'hF, 1, 0, "R9 write flags 0x12");
    idle(16'hFF0F, 1'b1, "R9 status vector");
    step(16'hFF0F, 8'h00, 1, 4'h0, 4'hF, 0, 0, "R9 clear flags");
    idle(16'hFF0F, 1'b0, "R9 cleared");
    // R10 keypad edges
    step(16'hFF0F, 8'h00, 0, 4'h0, 4'b1011, 0, 0, "R10 line 2 falls");
    step(16'hFF0F, 8'h00, 0, 4'h0, 4'b1011, 0, 0, "R10 keypad flag set");
    step(16'hFF0F, 8'h00, 1, 4'h0, 4'b1011, 0, 0, "R10 clear while held low");
    step(16'hFF0F, 8'h00, 0, 4'h0, 4'b1011, 0, 0, "R10 held low no set");
    step(16'hFF0F, 8'h00, 0, 4'h0, 4'hF, 0, 0, "R10 rising edge");
    step(16'hFF0F, 8'h00, 0, 4'h0, 4'hF, 1, 0, "R10 rising did not set");
    step(16'hFF0F, 8'h00, 0, 4'h0, 4'b0111, 1, 0, "R10 line 3 falls");
    idle(16'hFF0F, 1'b1, "R10 keypad vector");
    // R11 other address
    step(16'hFF10, 8'h00, 1, 4'h0, 4'hF, 1, 0, "R11 write elsewhere");
    idle(16'hFFFF, 1'b1, "R11 enables unchanged");
    // R3 mask keypad
    step(16'hFFFF, 8'h01, 1, 4'h0, 4'hF, 1, 0, "R3 enable only vblank");
    idle(16'hFF0F, 1'b1, "R3 keypad masked");
    idle(16'h1234, 1'b1, "R11 read elsewhere");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule